// File: doc/BRIEF.md
# Exception and Control-Register Unit

This unit keeps the control registers of a small processor core and handles entry into and return from software traps and breakpoints. Each cycle it receives one decoded control operation (read or write of a control register, exception return, breakpoint return), two independent entry requests (trap and break), a control-register index, a destination register index, the A operand and the PC of the current instruction. In the same cycle it answers with a register-file write request (enable, index, data) and a PC redirect (valid and target). Control-register state changes take effect at the next clock edge.

Control register 0 is the status word, 1 holds the status saved by a trap, and 2 holds the status saved by a break. Trap and break entry write the return address into fixed register-file slots (29 for traps, 30 for breaks). For an exception or breakpoint return, the decoder places the contents of slot 29 or 30 on the A operand, and the unit redirects the PC to that value. The unit does not hold the register file. It only issues write requests to it.

Top module: `ctl_trap_unit`

## Requirements
- R1: After reset, status (index 0), saved-trap status (index 1) and saved-break status (index 2) read as zero, and `status_q` is zero.
- R2: A control write (`op_code` = 2) stores `opnd_a` into the control register at `creg_idx`. A write to index 0 appears on `status_q` in the next cycle.
- R3: A control read (`op_code` = 1) raises `rf_we` in the same cycle, with `rf_waddr` = `dst_idx` and `rf_wdata` equal to the pre-edge contents of the register at `creg_idx`. An index of `NCTL` or above reads as zero, and a write to such an index changes no register.
- R4: A trap (`exc_req`) copies status into index 1 and clears status bits [1:0] at the next edge. All other status bits are kept.
- R5: In the cycle of a trap, the unit requests a register-file write of `pc_in + 4` to index 29 and a redirect to `EXC_ADDR`.
- R6: A break (`brk_req`) copies status into index 2 and clears status bits [1:0]. In the same cycle it requests a write of `pc_in + 4` to index 30 and a redirect to `BRK_ADDR`.
- R7: An exception return (`op_code` = 3) loads status from index 1 and redirects the PC to `opnd_a`, with no register-file write.
- R8: A breakpoint return (`op_code` = 4) loads status from index 2 and redirects the PC to `opnd_a`, with no register-file write.
- R9: Without a trap, break or return, `pc_redir` is low. `rf_we` is high only for a control read, a trap or a break. Codes 0, 5, 6 and 7 do nothing.
- R10: A trap takes precedence over a break, and either one suppresses the `op_code` operation of the same cycle, including a control write to status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Trap entry request |
| brk_req | input | 1 | Breakpoint entry request |
| op_code | input | 3 | 0 none, 1 control read, 2 control write, 3 exception return, 4 breakpoint return |
| creg_idx | input | IW | Control-register index |
| dst_idx | input | IW | Register-file destination for a control read |
| opnd_a | input | DW | A operand (write data, or return address for returns) |
| pc_in | input | DW | PC of the current instruction |
| rf_we | output | 1 | Register-file write request |
| rf_waddr | output | IW | Register-file write index |
| rf_wdata | output | DW | Register-file write data |
| pc_redir | output | 1 | PC redirect valid; suppresses the normal increment |
| pc_target | output | DW | Redirect target |
| status_q | output | DW | Current status word |

## Verification
The hardest situation to reach is a return whose restored status differs from the current status, or a trap that arrives together with a status write. Reaching it needs a status write with bits [1:0] set, then an entry, then a further status change before the matching return. The bench runs that sequence in a directed phase. It then runs a long random phase in which trap and break requests collide with each other and with every operation code, and with indices beyond `NCTL`. A behavioural model checks every output on every cycle.

// File: rtl/ctl_trap_unit.sv
module ctl_trap_unit #(
  parameter int DW = 32,
  parameter int IW = 5,
  parameter int NCTL = 8,
  parameter logic [DW-1:0] EXC_ADDR = 32'h0000_0020,
  parameter logic [DW-1:0] BRK_ADDR = 32'h0000_0040,
  parameter int EA_IDX = 29,
  parameter int BA_IDX = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_req,
  input  logic          brk_req,
  input  logic [2:0]    op_code,
  input  logic [IW-1:0] creg_idx,
  input  logic [IW-1:0] dst_idx,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] pc_in,
  output logic          rf_we,
  output logic [IW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          pc_redir,
  output logic [DW-1:0] pc_target,
  output logic [DW-1:0] status_q
);
  localparam int CW = $clog2(NCTL);
  localparam logic [IW:0] NCTL_W = (IW+1)'(NCTL);
  localparam logic [2:0] OP_RD = 3'd1, OP_WR = 3'd2, OP_ERET = 3'd3, OP_BRET = 3'd4;

  logic [DW-1:0] creg [NCTL];

  wire take_exc = exc_req;
  wire take_brk = brk_req & ~exc_req;
  wire plain    = ~exc_req & ~brk_req;
  wire idx_ok   = {1'b0, creg_idx} < NCTL_W;
  wire [DW-1:0] rd_val  = idx_ok ? creg[creg_idx[CW-1:0]] : '0;
  wire [DW-1:0] ret_adr = pc_in + DW'(4);
  wire [DW-1:0] masked  = creg[0] & ~DW'(3);

  assign status_q = creg[0];

  always_comb begin
    rf_we     = 1'b0;
    rf_waddr  = '0;
    rf_wdata  = '0;
    pc_redir  = 1'b0;
    pc_target = '0;
    if (take_exc) begin
      rf_we     = 1'b1;
      rf_waddr  = IW'(EA_IDX);
      rf_wdata  = ret_adr;
      pc_redir  = 1'b1;
      pc_target = EXC_ADDR;
    end else if (take_brk) begin
      rf_we     = 1'b1;
      rf_waddr  = IW'(BA_IDX);
      rf_wdata  = ret_adr;
      pc_redir  = 1'b1;
      pc_target = BRK_ADDR;
    end else begin
      case (op_code)
        OP_RD: begin
          rf_we    = 1'b1;
          rf_waddr = dst_idx;
          rf_wdata = rd_val;
        end
        OP_ERET, OP_BRET: begin
          pc_redir  = 1'b1;
          pc_target = opnd_a;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCTL; i++) creg[i] <= '0;
    end else if (take_exc) begin
      creg[1] <= creg[0];
      creg[0] <= masked;
    end else if (take_brk) begin
      creg[2] <= creg[0];
      creg[0] <= masked;
    end else if (plain) begin
      case (op_code)
        OP_WR:   if (idx_ok) creg[creg_idx[CW-1:0]] <= opnd_a;
        OP_ERET: creg[0] <= creg[1];
        OP_BRET: creg[0] <= creg[2];
        default: ;
      endcase
    end
  end
endmodule

module ctl_trap_unit_chk #(
  parameter int DW = 32,
  parameter int IW = 5,
  parameter logic [DW-1:0] EXC_ADDR = 32'h0000_0020,
  parameter logic [DW-1:0] BRK_ADDR = 32'h0000_0040,
  parameter int EA_IDX = 29,
  parameter int BA_IDX = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exc_req,
  input logic          brk_req,
  input logic [2:0]    op_code,
  input logic [IW-1:0] creg_idx,
  input logic [IW-1:0] dst_idx,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] pc_in,
  input logic          rf_we,
  input logic [IW-1:0] rf_waddr,
  input logic [DW-1:0] rf_wdata,
  input logic          pc_redir,
  input logic [DW-1:0] pc_target,
  input logic [DW-1:0] status_q
);
  AST_RESET_STATUS: assert property (@(posedge clk) !rst_n |=> status_q == '0); // R1
  AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !brk_req && op_code == 3'd2 && creg_idx == '0) |=> status_q == $past(opnd_a)); // R2
  AST_READ_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !brk_req && op_code == 3'd1) |-> (rf_we && rf_waddr == dst_idx && !pc_redir)); // R3
  AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req || brk_req) |=> status_q == ($past(status_q) & ~DW'(3))); // R4
  AST_TRAP_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (pc_redir && pc_target == EXC_ADDR && rf_we && rf_waddr == IW'(EA_IDX) && rf_wdata == pc_in + DW'(4))); // R5
  AST_BRK_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !exc_req) |-> (pc_redir && pc_target == BRK_ADDR && rf_we && rf_waddr == IW'(BA_IDX) && rf_wdata == pc_in + DW'(4))); // R6
  AST_RET_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !brk_req && (op_code == 3'd3 || op_code == 3'd4)) |-> (pc_redir && pc_target == opnd_a && !rf_we)); // R7
  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !brk_req && op_code != 3'd3 && op_code != 3'd4) |-> !pc_redir); // R9
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !brk_req && op_code != 3'd1) |-> !rf_we); // R9
endmodule

bind ctl_trap_unit ctl_trap_unit_chk #(
  .DW(DW), .IW(IW), .EXC_ADDR(EXC_ADDR), .BRK_ADDR(BRK_ADDR), .EA_IDX(EA_IDX), .BA_IDX(BA_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .brk_req(brk_req), .op_code(op_code),
  .creg_idx(creg_idx), .dst_idx(dst_idx), .opnd_a(opnd_a), .pc_in(pc_in),
  .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .pc_redir(pc_redir),
  .pc_target(pc_target), .status_q(status_q)
);

// File: tb/sim_ctl_trap_unit.sv
module sim_ctl_trap_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_req = 1'b0, brk_req = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [4:0] creg_idx = '0, dst_idx = '0;
  logic [31:0] opnd_a = '0, pc_in = '0;
  logic rf_we, pc_redir;
  logic [4:0] rf_waddr;
  logic [31:0] rf_wdata, pc_target, status_q;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [31:0] m [8];

  always #10 clk = ~clk;

  ctl_trap_unit u0 (.clk(clk), .rst_n(rst_n), .exc_req(exc_req), .brk_req(brk_req),
    .op_code(op_code), .creg_idx(creg_idx), .dst_idx(dst_idx), .opnd_a(opnd_a), .pc_in(pc_in),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .pc_redir(pc_redir),
    .pc_target(pc_target), .status_q(status_q));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit e, bit b, logic [2:0] op, int ci, int di, logic [31:0] a, logic [31:0] pc);
    logic ewe, ered;
    logic [4:0] ewa;
    logic [31:0] ewd, etg;
    string tag;
    @(negedge clk);
    exc_req = e; brk_req = b; op_code = op; creg_idx = 5'(ci); dst_idx = 5'(di);
    opnd_a = a; pc_in = pc;
    ewe = 0; ered = 0; ewa = 0; ewd = 0; etg = 0;
    if (e) begin
      tag = b ? "R10" : "R5"; ewe = 1; ewa = 29; ewd = pc + 4; ered = 1; etg = 32'h20;
    end else if (b) begin
      tag = "R6"; ewe = 1; ewa = 30; ewd = pc + 4; ered = 1; etg = 32'h40;
    end else if (op == 1) begin
      tag = "R3"; ewe = 1; ewa = 5'(di); ewd = (ci < 8) ? m[ci] : 32'h0;
    end else if (op == 3) begin
      tag = "R7"; ered = 1; etg = a;
    end else if (op == 4) begin
      tag = "R8"; ered = 1; etg = a;
    end else begin
      tag = (op == 2) ? "R2" : "R9";
    end
    #5;
    chk(tag, "rf_we", 32'(rf_we), 32'(ewe));
    if (ewe) begin
      chk(tag, "rf_waddr", 32'(rf_waddr), 32'(ewa));
      chk(tag, "rf_wdata", rf_wdata, ewd);
    end
    chk(tag, "pc_redir", 32'(pc_redir), 32'(ered));
    if (ered) chk(tag, "pc_target", pc_target, etg);
    chk(tag, "status_q", status_q, m[0]);
    @(posedge clk);
    if (e) begin m[1] = m[0]; m[0] = m[0] & ~32'h3; end
    else if (b) begin m[2] = m[0]; m[0] = m[0] & ~32'h3; end
    else if (op == 2) begin if (ci < 8) m[ci] = a; end
    else if (op == 3) m[0] = m[1];
    else if (op == 4) m[0] = m[2];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state of status and the two saved copies
    step(0, 0, 1, 0, 3, 0, 32'h100);
    step(0, 0, 1, 1, 4, 0, 32'h104);
    step(0, 0, 1, 2, 5, 0, 32'h108);
    // R2: control writes, including status with low bits set
    step(0, 0, 2, 0, 0, 32'hA5A5_0003, 0);
    step(0, 0, 2, 5, 0, 32'h1234_5678, 0);
    step(0, 0, 1, 5, 7, 0, 0);
    // R3: out-of-range index reads zero and its write is dropped
    step(0, 0, 2, 9, 0, 32'hDEAD_BEEF, 0);
    step(0, 0, 1, 9, 8, 0, 0);
    // R4 R5: trap saves status, clears low bits, writes ea, redirects
    step(1, 0, 0, 0, 0, 0, 32'h0000_1000);
    step(0, 0, 1, 1, 2, 0, 0);
    step(0, 0, 2, 0, 0, 32'h0000_00F1, 0);
    // R6: break saves into the break copy
    step(0, 1, 0, 0, 0, 0, 32'h0000_2000);
    step(0, 0, 1, 2, 6, 0, 0);
    // R8: breakpoint return restores from the break copy
    step(0, 0, 4, 0, 0, 32'h0000_2004, 0);
    // R7: exception return restores from the trap copy
    step(0, 0, 3, 0, 0, 32'h0000_1004, 0);
    // R9: idle and unused codes
    step(0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h40);
    step(0, 0, 6, 0, 1, 32'hFFFF_FFFF, 32'h44);
    // R10: trap wins over a status write and over break
    step(1, 0, 2, 0, 0, 32'hFFFF_FFFF, 32'h3000);
    step(1, 1, 2, 0, 0, 32'h0000_0007, 32'h3100);
    step(0, 1, 3, 0, 0, 32'h0000_0005, 32'h3200);
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 15);
      step(r == 0, r == 1 || (r == 0 && $urandom_range(0, 1) == 1), 3'($urandom_range(0, 7)),
           $urandom_range(0, 10), $urandom_range(0, 31), $urandom, $urandom & 32'hFFFF_FFFC);
    end
    finish_run();
  end
endmodule